// File: doc/BRIEF.md
# Counter-Ramp Analog-to-Digital Conversion Controller

This block sequences a stairstep-ramp converter. A binary count starting at zero is driven straight out as the code of an external DAC and climbs by one every clock. An external comparator compares the DAC level with the analog input and reports one bit back. When that bit says the DAC has reached the input, the code that caused the trip is stored as the result. A one-cycle strobe marks the new result, and the ramp starts again from zero. Conversion time therefore depends on the data: small inputs give frequent results and large inputs give sparse ones.

The comparator bit is asynchronous to the controller. It crosses through a chain of `SYNC_STAGES` flops. Each code sent to the DAC travels through a matching tag pipeline, so a trip is credited to the exact code that produced it and not to the later code already on the DAC. After a restart the pipeline is flushed, so comparator samples from the previous ramp are never used.

Top module: `ramp_adc`

## Requirements
- R1: `dac_code_o` is 0 in the first cycle of a conversion and rises by exactly one per clock after that. The only exception is the all-ones code, where it holds.
- R2: `cmp_i` = 1 means the DAC level is at or above the input. `cmp_i` passes through `SYNC_STAGES` flops. The stored result is the lowest code of the ramp for which the comparator read 1.
- R3: At the end of a conversion the result is written to `result_o` and `valid_o` is 1. In that same cycle `dac_code_o` is back at 0.
- R4: Successive `valid_o` pulses are `result_o + SYNC_STAGES + 1` clocks apart. The first pulse after reset is the same number of clocks after reset is released.
- R5: `result_o` does not change in any cycle in which `valid_o` is 0.
- R6: If no trip is seen for any code up to all-ones, the counter holds at all-ones. It then stores all-ones as a full-scale result and restarts from 0.
- R7: `valid_o` is high for exactly one clock per result.
- R8: Asserting `rst_ni` low (asynchronous, active low) clears `dac_code_o`, `result_o` and `valid_o` to 0 at once, along with the synchroniser and tag pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmp_i | input | 1 | Comparator bit, 1 when the DAC level is at or above the analog input |
| dac_code_o | output | WIDTH | Ramp code driven to the external DAC |
| result_o | output | WIDTH | Last completed conversion result |
| valid_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The assertions depend only on the counter, the strobe and the holding register. They take for granted that the comparator settles within one clock of a code change. Exact results also require the comparator to be monotonic within one ramp: once it reads 1 for a code, it reads 1 for every higher code of that ramp. The bench models the comparator as `dac_code_o >= target`, with `target` held constant across every conversion whose result is scored. A conversion during which the target was changed is discarded without being checked.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;
  localparam int unsigned DEF_WIDTH = 8;
  localparam int unsigned DEF_SYNC  = 2;
endpackage

// File: rtl/ramp_adc_sync.sv
module ramp_adc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/ramp_adc_tag_pipe.sv
// Carries each DAC code alongside its comparator sample through the synchroniser.
module ramp_adc_tag_pipe #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [WIDTH-1:0] code_i,
  output logic [WIDTH-1:0] code_o,
  output logic             vld_o
);
  logic [WIDTH-1:0] code_q [STAGES];
  logic [STAGES-1:0] vld_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] code_in;
    if (s == 0) begin : g_head
      assign code_in = code_i;
    end else begin : g_body
      assign code_in = code_q[s-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        code_q[s] <= '0;
        vld_q[s]  <= 1'b0;
      end else begin
        code_q[s] <= code_in;
        vld_q[s]  <= flush_i ? 1'b0 : ((s == 0) ? 1'b1 : vld_q[s-1]);
      end
    end
  end

  assign code_o = code_q[STAGES-1];
  assign vld_o  = vld_q[STAGES-1];
endmodule

// File: rtl/ramp_adc_counter.sv
module ramp_adc_counter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  output logic [WIDTH-1:0] cnt_o
);
  localparam logic [WIDTH-1:0] CntMax = {WIDTH{1'b1}};

  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (restart_i)       cnt_q <= '0;
    else if (cnt_q != CntMax) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ramp_adc.sv
module ramp_adc
  import ramp_adc_pkg::*;
#(
  parameter int unsigned WIDTH       = DEF_WIDTH,
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] dac_code_o,
  output logic [WIDTH-1:0] result_o,
  output logic             valid_o
);
  localparam logic [WIDTH-1:0] CodeMax = {WIDTH{1'b1}};

  logic             cmp_s;
  logic [WIDTH-1:0] cnt;
  logic [WIDTH-1:0] tag_code;
  logic             tag_vld;
  logic             restart;
  logic [WIDTH-1:0] result_q;
  logic             valid_q;

  ramp_adc_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_i),
    .q_o   (cmp_s)
  );

  ramp_adc_counter #(.WIDTH(WIDTH)) i_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .cnt_o    (cnt)
  );

  ramp_adc_tag_pipe #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_tag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(restart),
    .code_i (cnt),
    .code_o (tag_code),
    .vld_o  (tag_vld)
  );

  // trip on the aligned sample, or give up once the all-ones code has been judged
  assign restart = tag_vld && (cmp_s || (tag_code == CodeMax));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= restart;
      if (restart) result_q <= tag_code;
    end
  end

  assign dac_code_o = cnt;
  assign result_o   = result_q;
  assign valid_o    = valid_q;
endmodule

// File: rtl/ramp_adc_chk.sv
module ramp_adc_chk #(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] dac_code_o,
  input logic [WIDTH-1:0] result_o,
  input logic             valid_o
);
  localparam logic [WIDTH-1:0] CodeMax = {WIDTH{1'b1}};
  localparam int unsigned GW = WIDTH + 2;

  logic             seen_q;
  logic [WIDTH-1:0] prev_dac_q;
  logic [WIDTH-1:0] prev_res_q;
  logic [GW-1:0]    gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q     <= 1'b0;
      prev_dac_q <= '0;
      prev_res_q <= '0;
      gap_q      <= '0;
    end else begin
      seen_q     <= 1'b1;
      prev_dac_q <= dac_code_o;
      prev_res_q <= result_o;
      if (valid_o)               gap_q <= GW'(1);
      else if (gap_q != '1)      gap_q <= gap_q + 1'b1;
    end
  end

  AST_RAMP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !valid_o) |-> ((dac_code_o == WIDTH'(prev_dac_q + 1'b1)) ||
                              (dac_code_o == CodeMax && prev_dac_q == CodeMax))); // R1

  AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (dac_code_o == '0)); // R3

  AST_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (gap_q == GW'(result_o) + GW'(SYNC_STAGES + 1))); // R4

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !valid_o) |-> (result_o == prev_res_q)); // R5

  AST_ONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R7
endmodule

bind ramp_adc ramp_adc_chk #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .dac_code_o(dac_code_o),
  .result_o  (result_o),
  .valid_o   (valid_o)
);

// File: tb/test_ramp_adc.sv
module test_ramp_adc;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 8;
  localparam int SYNC = 2;
  localparam int MAXV = (1 << W) - 1;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cmp_i;
  logic [W-1:0] dac_code_o;
  logic [W-1:0] result_o;
  logic         valid_o;
  int           target = 0;
  int           n_vec = 0;
  int           n_err = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // behavioural DAC plus comparator
  always_comb cmp_i = (int'(dac_code_o) >= target);

  ramp_adc #(.WIDTH(W), .SYNC_STAGES(SYNC)) i_ramp_adc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmp_i     (cmp_i),
    .dac_code_o(dac_code_o),
    .result_o  (result_o),
    .valid_o   (valid_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk_i);
      if (valid_o) return;
    end
    check("R4 strobe timeout", 0, 1);
  endtask

  // Measure one full conversion from a strobe to the next, checking ramp and hold.
  task automatic measure(input int exp_res, input string tag);
    int cycles;
    logic [W-1:0] held;
    logic [W-1:0] prev;
    bit ramp_ok;
    bit hold_ok;
    cycles  = 0;
    held    = result_o;
    prev    = dac_code_o;
    ramp_ok = 1'b1;
    hold_ok = 1'b1;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk_i);
      cycles++;
      if (valid_o) break;
      if (result_o != held) hold_ok = 1'b0;
      if (!((int'(dac_code_o) == int'(prev) + 1) ||
            (int'(dac_code_o) == MAXV && int'(prev) == MAXV))) ramp_ok = 1'b0;
      prev = dac_code_o;
    end
    check({"R2/R6 result ", tag}, int'(result_o), exp_res);
    check({"R4 period ", tag}, cycles, exp_res + SYNC + 1);
    check({"R3 restart code ", tag}, int'(dac_code_o), 0);
    check({"R5 hold ", tag}, int'(hold_ok), 1);
    check({"R1 ramp ", tag}, int'(ramp_ok), 1);
    @(negedge clk_i);
    check({"R7 single pulse ", tag}, int'(valid_o), 0);
    check({"R1 first step ", tag}, int'(dac_code_o), 1);
  endtask

  task automatic t_reset_start();
    target = 10;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R8 reset dac", int'(dac_code_o), 0);
    check("R8 reset result", int'(result_o), 0);
    check("R8 reset valid", int'(valid_o), 0);
    rst_ni = 1'b1;
    begin
      int cycles;
      cycles = 0;
      for (int i = 0; i < 1000; i++) begin
        @(negedge clk_i);
        cycles++;
        if (valid_o) break;
      end
      check("R8 first period after reset", cycles, 10 + SYNC + 1);
      check("R2 first result", int'(result_o), 10);
    end
  endtask

  task automatic t_convert(input int tgt, input int exp_res, input string tag);
    target = tgt;
    wait_valid();   // conversion in flight may straddle the change
    measure(exp_res, tag);
    wait_valid();
    measure(exp_res, tag);
  endtask

  task automatic t_reset_mid();
    target = 200;
    wait_valid();
    repeat (50) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R8 async clear dac", int'(dac_code_o), 0);
    check("R8 async clear result", int'(result_o), 0);
    check("R8 async clear valid", int'(valid_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    wait_valid();
    check("R2 result after mid reset", int'(result_o), 200);
  endtask

  initial begin
    t_reset_start();
    t_convert(0,    0,    "zero");
    t_convert(1,    1,    "one");
    t_convert(5,    5,    "five");
    t_convert(37,   37,   "low");
    t_convert(128,  128,  "mid");
    t_convert(MAXV - 1, MAXV - 1, "near top");
    t_convert(MAXV, MAXV, "top R6");
    t_convert(300,  MAXV, "over range R6");
    t_reset_mid();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule